// File: doc/BRIEF.md
# Pulse Accumulator with Event and Gated-Time Modes

This block is a 16-bit pulse accumulator attached to a simple synchronous register bus. In event mode it adds one to its count for every active edge seen on an external input pin. In gated time mode it adds one on each cycle where a prescaled clock enable arrives while the same pin, used as a gate, sits at its active level. The pin passes through a two-flop synchronizer before edge detection. The block raises two sticky flags, one for wrap-around of the count and one for input activity. Software clears them by writing ones, or through an optional fast-clear mode in which any count access clears both.

A mode state machine drives the counting. Its states are ST_OFF (disabled), ST_EVENT (edge counting), ST_GATE_IDLE (gated mode, gate inactive) and ST_GATE_ON (gated mode, gate active). ST_OFF goes to ST_EVENT or ST_GATE_IDLE when the enable bit is set, depending on the mode bit. Every other state returns to ST_OFF when the enable bit is cleared. ST_EVENT and the two gated states move between each other when the mode bit changes. ST_GATE_IDLE goes to ST_GATE_ON when the synchronized gate reaches its active level, which is the leading edge. ST_GATE_ON goes back to ST_GATE_IDLE when the gate leaves its active level, which is the trailing edge, and that transition raises the input flag.

Bus addresses: 0 is control, 1 is flags, 2 and 3 are the count. Accesses complete in the cycle the strobe is high, and read data is combinational.

Top module: `pulse_accum`

## Requirements
- R1: After reset, the control register, the flag register and the count all read as zero.
- R2: With control bit 0 set and bit 1 clear (event mode), the count goes up by exactly one for each selected pin edge. The increment lands three clock edges after the pin changes.
- R3: In event mode, control bit 2 picks the counted edge: 0 counts rising edges, 1 counts falling edges. The other edge has no effect.
- R4: In event mode, each counted edge sets flag bit 0.
- R5: A count step from 0xFFFF to 0x0000 sets flag bit 1.
- R6: With control bits 0 and 1 set (gated mode), the count goes up by one on each cycle where gate_tick is high and the synchronized pin is at its active level. Control bit 2 at 0 makes high the active level, and at 1 makes low the active level. Ticks while the gate is inactive are not counted.
- R7: In gated mode, flag bit 0 is set when the gate leaves its active level, and not when it enters it.
- R8: A write to address 1 clears each flag whose data bit is 1: bit 1 clears the overflow flag and bit 0 clears the input flag. Zero bits leave flags unchanged, and bits 15 to 2 of the flag register read as zero.
- R9: When control bit 3 is set, any read or write at address 2 or 3 clears both flags. A flag set in the same cycle still wins.
- R10: With bus_word high, an access at address 2 or 3 reads or writes all 16 count bits in one cycle. With bus_word low, address 2 is the high byte and address 3 the low byte, using data bits 7 to 0, and reads are zero-extended.
- R11: With control bit 0 clear, neither pin activity nor ticks change the count or the flags.
- R12: A software write to the count in the same cycle as an increment takes the written value, and the increment is dropped.
- R13: Control bits 3 to 0 read back as written at address 0, and the upper bits read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pa_pin | input | 1 | Asynchronous pulse or gate input |
| gate_tick | input | 1 | Single-cycle prescaled clock enable for gated mode |
| bus_addr | input | 2 | Register address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_word | input | 1 | 1 for 16-bit access, 0 for byte access |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational |

## Verification
The properties assume the bus never raises read and write together, and that gate_tick is a plain single-cycle enable. They also assume the pin holds each level long enough for the synchronizer to capture it. The stimulus changes every input only on falling clock edges and issues one strobe per access with idle cycles in between. It holds the pin at each level for four cycles. One case places a count write on the exact cycle of an increment, to exercise the write-priority path.

// File: rtl/pa_pkg.sv
package pa_pkg;
    typedef enum logic [1:0] {
        ST_OFF,
        ST_EVENT,
        ST_GATE_IDLE,
        ST_GATE_ON
    } pa_state_t;

    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_FLAG = 2'd1;

    localparam int C_EN    = 0;
    localparam int C_GATED = 1;
    localparam int C_POL   = 2;
    localparam int C_FCLR  = 3;
    localparam int CTRL_W  = 4;

    localparam int F_EDGE  = 0;
    localparam int F_OVF   = 1;
    localparam int FLAG_W  = 2;
endpackage

// File: rtl/pa_edge_sync.sv
module pa_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic lvl_o,
    output logic prev_o
);
    logic [STAGES:0] chain_q;

    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-1:0], pin_i};
    end

    assign lvl_o  = chain_q[STAGES-1];
    assign prev_o = chain_q[STAGES];
endmodule

// File: rtl/pa_mode_fsm.sv
module pa_mode_fsm
    import pa_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic gated_i,
    input  logic pol_i,
    input  logic lvl_i,
    input  logic prev_i,
    input  logic tick_i,
    output logic inc_o,
    output logic edge_set_o
);
    pa_state_t state_q, state_d;
    logic sel_lvl, sel_prev, hit;

    assign sel_lvl  = lvl_i ^ pol_i;
    assign sel_prev = prev_i ^ pol_i;
    assign hit      = sel_lvl & ~sel_prev;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:       if (en_i) state_d = gated_i ? ST_GATE_IDLE : ST_EVENT;
            ST_EVENT:     if (!en_i) state_d = ST_OFF;
                          else if (gated_i) state_d = ST_GATE_IDLE;
            ST_GATE_IDLE: if (!en_i) state_d = ST_OFF;
                          else if (!gated_i) state_d = ST_EVENT;
                          else if (sel_lvl) state_d = ST_GATE_ON;
            ST_GATE_ON:   if (!en_i) state_d = ST_OFF;
                          else if (!gated_i) state_d = ST_EVENT;
                          else if (!sel_lvl) state_d = ST_GATE_IDLE;
            default:      state_d = ST_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        inc_o      = 1'b0;
        edge_set_o = 1'b0;
        unique case (state_q)
            ST_OFF: ;
            ST_EVENT: if (en_i && !gated_i) begin
                inc_o      = hit;
                edge_set_o = hit;
            end
            ST_GATE_IDLE: if (en_i && gated_i) begin
                inc_o = tick_i & sel_lvl;
            end
            ST_GATE_ON: if (en_i && gated_i) begin
                inc_o      = tick_i & sel_lvl;
                edge_set_o = ~sel_lvl;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/pa_count_regs.sv
module pa_count_regs
    import pa_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        addr_i,
    input  logic              rd_i,
    input  logic              wr_i,
    input  logic              word_i,
    input  logic [CNT_W-1:0]  wdata_i,
    input  logic              inc_i,
    input  logic              edge_set_i,
    output logic [CNT_W-1:0]  rdata_o,
    output logic [CTRL_W-1:0] ctrl_o,
    output logic [CNT_W-1:0]  cnt_o,
    output logic [FLAG_W-1:0] flag_o,
    output logic              ovf_set_o
);
    localparam int HALF = CNT_W / 2;

    logic [CTRL_W-1:0] ctrl_q;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [FLAG_W-1:0] flag_q, flag_d;
    logic cnt_acc, cnt_wr;

    assign cnt_acc   = (rd_i | wr_i) & addr_i[1];
    assign cnt_wr    = wr_i & addr_i[1];
    assign ovf_set_o = inc_i & ~cnt_wr & (cnt_q == {CNT_W{1'b1}});

    always_comb begin
        cnt_d = cnt_q;
        if (cnt_wr) begin
            if (word_i)         cnt_d = wdata_i;
            else if (addr_i[0]) cnt_d = {cnt_q[CNT_W-1:HALF], wdata_i[HALF-1:0]};
            else                cnt_d = {wdata_i[HALF-1:0], cnt_q[HALF-1:0]};
        end else if (inc_i) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_comb begin
        flag_d = flag_q;
        if (wr_i && addr_i == A_FLAG) flag_d = flag_d & ~wdata_i[FLAG_W-1:0];
        if (ctrl_q[C_FCLR] && cnt_acc) flag_d = '0;
        flag_d[F_EDGE] = flag_d[F_EDGE] | edge_set_i;
        flag_d[F_OVF]  = flag_d[F_OVF]  | ovf_set_o;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            cnt_q  <= '0;
            flag_q <= '0;
        end else begin
            if (wr_i && addr_i == A_CTRL) ctrl_q <= wdata_i[CTRL_W-1:0];
            cnt_q  <= cnt_d;
            flag_q <= flag_d;
        end
    end

    always_comb begin
        rdata_o = '0;
        if (addr_i[1]) begin
            if (word_i)         rdata_o = cnt_q;
            else if (addr_i[0]) rdata_o = {{HALF{1'b0}}, cnt_q[HALF-1:0]};
            else                rdata_o = {{HALF{1'b0}}, cnt_q[CNT_W-1:HALF]};
        end else if (addr_i == A_FLAG) begin
            rdata_o = {{(CNT_W-FLAG_W){1'b0}}, flag_q};
        end else begin
            rdata_o = {{(CNT_W-CTRL_W){1'b0}}, ctrl_q};
        end
    end

    assign ctrl_o = ctrl_q;
    assign cnt_o  = cnt_q;
    assign flag_o = flag_q;
endmodule

// File: rtl/pulse_accum.sv
module pulse_accum
    import pa_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pa_pin,
    input  logic             gate_tick,
    input  logic [1:0]       bus_addr,
    input  logic             bus_rd,
    input  logic             bus_wr,
    input  logic             bus_word,
    input  logic [CNT_W-1:0] bus_wdata,
    output logic [CNT_W-1:0] bus_rdata
);
    logic              lvl_w, prev_w, inc_w, edge_set_w, ovf_set_w;
    logic [CTRL_W-1:0] ctrl_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [FLAG_W-1:0] flag_q;

    pa_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (pa_pin),
        .lvl_o  (lvl_w),
        .prev_o (prev_w)
    );

    pa_mode_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (ctrl_q[C_EN]),
        .gated_i    (ctrl_q[C_GATED]),
        .pol_i      (ctrl_q[C_POL]),
        .lvl_i      (lvl_w),
        .prev_i     (prev_w),
        .tick_i     (gate_tick),
        .inc_o      (inc_w),
        .edge_set_o (edge_set_w)
    );

    pa_count_regs #(.CNT_W(CNT_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_i     (bus_addr),
        .rd_i       (bus_rd),
        .wr_i       (bus_wr),
        .word_i     (bus_word),
        .wdata_i    (bus_wdata),
        .inc_i      (inc_w),
        .edge_set_i (edge_set_w),
        .rdata_o    (bus_rdata),
        .ctrl_o     (ctrl_q),
        .cnt_o      (cnt_q),
        .flag_o     (flag_q),
        .ovf_set_o  (ovf_set_w)
    );
endmodule

// File: rtl/pa_checker.sv
module pa_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       bus_addr,
    input logic             bus_rd,
    input logic             bus_wr,
    input logic             bus_word,
    input logic [CNT_W-1:0] bus_wdata,
    input logic [CNT_W-1:0] bus_rdata,
    input logic [3:0]       ctrl_q,
    input logic [CNT_W-1:0] cnt_q,
    input logic [1:0]       flag_q,
    input logic             inc_w,
    input logic             edge_set_w,
    input logic             ovf_set_w
);
    logic cnt_wr;
    assign cnt_wr = bus_wr & bus_addr[1];

    AST_FLAG_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 2'd1) |-> (bus_rdata[CNT_W-1:2] == '0)); // R8

    AST_WRAP_SETS_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_w && cnt_q == {CNT_W{1'b1}} && !cnt_wr) |=> flag_q[1]); // R5

    AST_DISABLED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q[0] && !cnt_wr) |=> $stable(cnt_q)); // R11

    AST_WORD_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_wr && bus_word) |=> (cnt_q == $past(bus_wdata))); // R12

    AST_FAST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[3] && (bus_rd || bus_wr) && bus_addr[1] && !edge_set_w && !ovf_set_w)
        |=> (flag_q == 2'b00)); // R9

    AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_wr |=> (cnt_q == $past(cnt_q) || cnt_q == CNT_W'($past(cnt_q) + 1'b1))); // R2
endmodule

bind pulse_accum pa_checker #(.CNT_W(CNT_W)) u_pa_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_rd     (bus_rd),
    .bus_wr     (bus_wr),
    .bus_word   (bus_word),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .ctrl_q     (ctrl_q),
    .cnt_q      (cnt_q),
    .flag_q     (flag_q),
    .inc_w      (inc_w),
    .edge_set_w (edge_set_w),
    .ovf_set_w  (ovf_set_w)
);

// File: tb/tb_pulse_accum.sv
`timescale 1ns/100ps
module tb_pulse_accum;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pa_pin = 1'b0;
    logic        gate_tick = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_word = 1'b0;
    logic [15:0] bus_wdata = 16'd0;
    logic [15:0] bus_rdata;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [15:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    pulse_accum dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .pa_pin    (pa_pin),
        .gate_tick (gate_tick),
        .bus_addr  (bus_addr),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_word  (bus_word),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata)
    );

    // monitor: pops expected items and compares against the read data
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (bus_rd && exp_q.size() > 0) begin
                logic [15:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                n_chk++;
                if (bus_rdata !== e) begin
                    n_fail++;
                    $display("FAIL %s: read addr %0d got %h expected %h", t, bus_addr, bus_rdata, e);
                end
            end
        end
    end

    task automatic bus_write(input logic [1:0] a, input logic w, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_word = w; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_check(input logic [1:0] a, input logic w, input logic [15:0] e, input string t);
        @(negedge clk);
        bus_addr = a; bus_word = w; bus_rd = 1'b1;
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic pin_pulse();
        @(negedge clk); pa_pin = 1'b1;
        repeat (4) @(negedge clk);
        pa_pin = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); gate_tick = 1'b1;
            @(negedge clk); gate_tick = 1'b0;
        end
    endtask

    task automatic settle();
        repeat (5) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run hung, got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        bus_check(2'd0, 1'b0, 16'h0000, "R1");
        bus_check(2'd1, 1'b0, 16'h0000, "R1");
        bus_check(2'd2, 1'b1, 16'h0000, "R1");

        // R2/R4 event mode rising edges
        bus_write(2'd0, 1'b0, 16'h0001);
        repeat (3) pin_pulse();
        settle();
        bus_check(2'd2, 1'b1, 16'h0003, "R2");
        bus_check(2'd1, 1'b0, 16'h0001, "R4");

        // R8 write-one-to-clear
        bus_write(2'd1, 1'b0, 16'h0000);
        bus_check(2'd1, 1'b0, 16'h0001, "R8");
        bus_write(2'd1, 1'b0, 16'h0001);
        bus_check(2'd1, 1'b0, 16'h0000, "R8");

        // R3 falling edge select
        bus_write(2'd0, 1'b0, 16'h0005);
        repeat (2) pin_pulse();
        settle();
        bus_check(2'd2, 1'b1, 16'h0005, "R3");
        bus_write(2'd1, 1'b0, 16'h0003);

        // R10 word and byte access, R5 wrap
        bus_write(2'd2, 1'b1, 16'hFFFE);
        bus_check(2'd2, 1'b1, 16'hFFFE, "R10");
        bus_check(2'd2, 1'b0, 16'h00FF, "R10");
        bus_check(2'd3, 1'b0, 16'h00FE, "R10");
        repeat (2) pin_pulse();
        settle();
        bus_check(2'd2, 1'b1, 16'h0000, "R5");
        bus_check(2'd1, 1'b0, 16'h0003, "R5");
        bus_write(2'd1, 1'b0, 16'h0002);
        bus_check(2'd1, 1'b0, 16'h0001, "R8");
        bus_write(2'd1, 1'b0, 16'h0001);
        bus_write(2'd3, 1'b0, 16'h0034);
        bus_write(2'd2, 1'b0, 16'h0012);
        bus_check(2'd2, 1'b1, 16'h1234, "R10");
        bus_write(2'd2, 1'b1, 16'h0000);

        // R9 fast clear, R13 control readback
        bus_write(2'd0, 1'b0, 16'h000D);
        bus_check(2'd0, 1'b0, 16'h000D, "R13");
        pin_pulse();
        settle();
        bus_check(2'd1, 1'b0, 16'h0001, "R9");
        bus_check(2'd2, 1'b1, 16'h0001, "R9");
        bus_check(2'd1, 1'b0, 16'h0000, "R9");

        // R6/R7 gated, active high
        bus_write(2'd0, 1'b0, 16'h0003);
        @(negedge clk); pa_pin = 1'b1;
        settle();
        ticks(5);
        settle();
        bus_check(2'd2, 1'b1, 16'h0006, "R6");
        bus_check(2'd1, 1'b0, 16'h0000, "R7");
        @(negedge clk); pa_pin = 1'b0;
        settle();
        bus_check(2'd1, 1'b0, 16'h0001, "R7");
        ticks(3);
        settle();
        bus_check(2'd2, 1'b1, 16'h0006, "R6");
        bus_write(2'd1, 1'b0, 16'h0001);

        // R6 gated, active low
        bus_write(2'd0, 1'b0, 16'h0007);
        settle();
        ticks(2);
        settle();
        bus_check(2'd2, 1'b1, 16'h0008, "R6");
        bus_check(2'd1, 1'b0, 16'h0000, "R7");

        // R11 disabled
        bus_write(2'd0, 1'b0, 16'h0000);
        repeat (2) pin_pulse();
        ticks(3);
        settle();
        bus_check(2'd2, 1'b1, 16'h0008, "R11");
        bus_check(2'd1, 1'b0, 16'h0000, "R11");

        // R12 write collides with increment
        bus_write(2'd0, 1'b0, 16'h0001);
        settle();
        @(negedge clk); pa_pin = 1'b1;
        @(negedge clk);
        @(negedge clk);
        bus_addr = 2'd2; bus_word = 1'b1; bus_wdata = 16'h1234; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
        settle();
        bus_check(2'd2, 1'b1, 16'h1234, "R12");
        @(negedge clk); pa_pin = 1'b0;
        settle();
        pin_pulse();
        settle();
        bus_check(2'd2, 1'b1, 16'h1235, "R2");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL scoreboard: pending items got %0d expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule